// File: doc/BRIEF.md
# S-record stream decoder

The decoder takes a stream of ASCII characters, one per cycle when `char_valid_i` is high, and turns the Motorola S-records in it into single-byte memory writes. It finds the record start, reads the type digit, and converts pairs of hex digits into bytes. It then takes a 2-, 3- or 4-byte big-endian load address, chosen by the record type. Each data byte goes out as one write, and the address steps up by one for each byte. A running checksum, seeded with 0x01, must reach zero on the record's last byte.

Header (S0) and count (S5) records are checked but write nothing. Termination records (S7, S8, S9) signal end of file. They also report the lowest and highest addresses written since the previous end of file. Malformed input raises a one-cycle error with a cause code. The decoder then drops the record and waits for the next start character. Data bytes are written as they arrive, so a checksum failure does not undo writes already made. The system above the decoder decides what to do with the record.

Top module: `srec_decoder`

## Requirements
- R1: After reset all pulse outputs are low, `lo_addr_o` is all ones and `hi_addr_o` is zero.
- R2: An S1 record writes each data byte once, in order, starting at its 16-bit address, with the address rising by one per byte. A write appears the cycle after the byte's second hex digit is accepted.
- R3: S2 records carry a 24-bit address and S3 records a 32-bit address. In both, the address increments across the full 32-bit width.
- R4: The checksum starts at 0x01 and every byte after the type is added to it, the checksum byte included. If the result is 0x00, `rec_ok_o` pulses. Otherwise `err_o` pulses with code 4. `rec_ok_o`, `err_o` and a write never occur in the same cycle.
- R5: S0 and S5 records are checksum-validated like any other record but produce no writes.
- R6: A valid S7, S8 or S9 record pulses `eof_o` together with `rec_ok_o`.
- R7: A byte count smaller than the address length plus one (3 for types 0, 1, 5, 9; 4 for 2, 8; 5 for 3, 7) raises error code 3 as soon as the count byte completes.
- R8: A type character other than the digits 0-3, 5, 7, 8 or 9 raises error code 2.
- R9: A non-hex character inside a record raises error code 1. After any error, and between records, every character except 'S' is ignored, and decoding restarts at the next 'S'.
- R10: While `eof_o` is high, `lo_addr_o` and `hi_addr_o` hold the lowest and highest addresses written since the last end of file. In the cycle after, they return to all ones and zero.
- R11: The hex digits a-f are accepted in lower case as well as upper case.
- R12: A character presented while `char_valid_i` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| char_valid_i | input | 1 | `char_i` carries a character this cycle |
| char_i | input | 8 | ASCII character |
| wr_valid_o | output | 1 | Data byte write strobe |
| wr_addr_o | output | ADDR_W | Write address |
| wr_data_o | output | 8 | Write data byte |
| rec_ok_o | output | 1 | Record ended with a good checksum |
| eof_o | output | 1 | Valid termination record seen |
| err_o | output | 1 | Record aborted |
| err_code_o | output | 3 | Cause: 1 non-hex, 2 bad type, 3 count too small, 4 checksum |
| lo_addr_o | output | ADDR_W | Lowest address written, valid with `eof_o` |
| hi_addr_o | output | ADDR_W | Highest address written, valid with `eof_o` |

## Verification
The bench builds records of every address width, with counts and checksums it computes itself. The address values are chosen so that a byte-order or width mix-up changes the observed address; one S3 record crosses a 16-bit boundary. Corrupted checksums show that writes still happen but the record is flagged, not confirmed. Header and count records show validation without writes. Three termination types, each closing a different group of writes, show that the reported address range follows the writes and is cleared after each end of file. Lower-case digits, idle gaps carrying junk characters, and truncated or illegal records that are immediately followed by a good one tell the error causes apart and show that resynchronisation works.

// File: rtl/srec_pkg.sv
package srec_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_TYPE, ST_HI, ST_LO} st_e;
  typedef enum logic [1:0] {FLD_COUNT, FLD_ADDR, FLD_DATA} fld_e;
  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_HEX   = 3'd1,
    ERR_TYPE  = 3'd2,
    ERR_COUNT = 3'd3,
    ERR_SUM   = 3'd4
  } err_e;

  function automatic logic [2:0] addr_bytes(input logic [3:0] typ);
    case (typ)
      4'd2, 4'd8: addr_bytes = 3'd3;
      4'd3, 4'd7: addr_bytes = 3'd4;
      default:    addr_bytes = 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/srec_hexconv.sv
module srec_hexconv (
  input  logic [7:0] ch_i,
  output logic [3:0] nib_o,
  output logic       is_hex_o
);
  always_comb begin
    nib_o    = 4'd0;
    is_hex_o = 1'b1;
    if (ch_i >= "0" && ch_i <= "9")      nib_o = ch_i[3:0];
    else if (ch_i >= "A" && ch_i <= "F") nib_o = ch_i[3:0] + 4'd9;
    else if (ch_i >= "a" && ch_i <= "f") nib_o = ch_i[3:0] + 4'd9;
    else                                 is_hex_o = 1'b0;
  end
endmodule

// File: rtl/srec_range.sv
module srec_range #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              clr_i,
  output logic [ADDR_W-1:0] lo_o,
  output logic [ADDR_W-1:0] hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_o <= '1;
      hi_o <= '0;
    end else if (clr_i) begin
      lo_o <= '1;
      hi_o <= '0;
    end else if (wr_i) begin
      if (addr_i < lo_o) lo_o <= addr_i;
      if (addr_i > hi_o) hi_o <= addr_i;
    end
  end
endmodule

// File: rtl/srec_parser.sv
module srec_parser
  import srec_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ch_valid_i,
  input  logic [7:0]        ch_i,
  input  logic [3:0]        nib_i,
  input  logic              is_hex_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rec_ok_o,
  output logic              eof_o,
  output logic              err_o,
  output logic [2:0]        err_code_o
);
  st_e               st_q;
  fld_e              fld_q;
  err_e              err_q;
  logic [3:0]        typ_q;
  logic [3:0]        hi_q;
  logic [7:0]        rem_q;
  logic [2:0]        alen_q;
  logic [7:0]        sum_q;
  logic [ADDR_W-1:0] addr_q;

  logic [7:0] byte_w;
  logic [7:0] sum_w;
  logic [2:0] alen_w;
  logic       type_ok_w;
  logic       wr_type_w;
  logic       eof_type_w;

  assign byte_w     = {hi_q, nib_i};
  assign sum_w      = sum_q + byte_w;
  assign alen_w     = addr_bytes(typ_q);
  assign type_ok_w  = (ch_i >= "0") && (ch_i <= "9") && (ch_i != "4") && (ch_i != "6");
  assign wr_type_w  = (typ_q == 4'd1) || (typ_q == 4'd2) || (typ_q == 4'd3);
  assign eof_type_w = (typ_q == 4'd7) || (typ_q == 4'd8) || (typ_q == 4'd9);
  assign err_code_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      fld_q      <= FLD_COUNT;
      err_q      <= ERR_NONE;
      typ_q      <= '0;
      hi_q       <= '0;
      rem_q      <= '0;
      alen_q     <= '0;
      sum_q      <= '0;
      addr_q     <= '0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      rec_ok_o   <= 1'b0;
      eof_o      <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      wr_valid_o <= 1'b0;
      rec_ok_o   <= 1'b0;
      eof_o      <= 1'b0;
      err_o      <= 1'b0;
      if (ch_valid_i) begin
        case (st_q)
          ST_IDLE: if (ch_i == "S") st_q <= ST_TYPE;
          ST_TYPE: begin
            if (type_ok_w) begin
              typ_q  <= ch_i[3:0];
              fld_q  <= FLD_COUNT;
              sum_q  <= 8'h01;
              addr_q <= '0;
              st_q   <= ST_HI;
            end else begin
              err_o <= 1'b1;
              err_q <= ERR_TYPE;
              st_q  <= ST_IDLE;
            end
          end
          ST_HI: begin
            if (is_hex_i) begin
              hi_q <= nib_i;
              st_q <= ST_LO;
            end else begin
              err_o <= 1'b1;
              err_q <= ERR_HEX;
              st_q  <= ST_IDLE;
            end
          end
          ST_LO: begin
            if (!is_hex_i) begin
              err_o <= 1'b1;
              err_q <= ERR_HEX;
              st_q  <= ST_IDLE;
            end else begin
              sum_q <= sum_w;
              st_q  <= ST_HI;
              case (fld_q)
                FLD_COUNT: begin
                  if (byte_w < ({5'd0, alen_w} + 8'd1)) begin
                    err_o <= 1'b1;
                    err_q <= ERR_COUNT;
                    st_q  <= ST_IDLE;
                  end else begin
                    rem_q  <= byte_w;
                    alen_q <= alen_w;
                    fld_q  <= FLD_ADDR;
                  end
                end
                FLD_ADDR: begin
                  addr_q <= {addr_q[ADDR_W-9:0], byte_w};
                  alen_q <= alen_q - 3'd1;
                  rem_q  <= rem_q - 8'd1;
                  if (alen_q == 3'd1) fld_q <= FLD_DATA;
                end
                default: begin
                  if (rem_q == 8'd1) begin
                    st_q <= ST_IDLE;
                    if (sum_w == 8'h00) begin
                      rec_ok_o <= 1'b1;
                      eof_o    <= eof_type_w;
                    end else begin
                      err_o <= 1'b1;
                      err_q <= ERR_SUM;
                    end
                  end else begin
                    rem_q <= rem_q - 8'd1;
                    if (wr_type_w) begin
                      wr_valid_o <= 1'b1;
                      wr_addr_o  <= addr_q;
                      wr_data_o  <= byte_w;
                      addr_q     <= addr_q + 1'b1;
                    end
                  end
                end
              endcase
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/srec_decoder.sv
module srec_decoder #(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              char_valid_i,
  input  logic [7:0]        char_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              rec_ok_o,
  output logic              eof_o,
  output logic              err_o,
  output logic [2:0]        err_code_o,
  output logic [ADDR_W-1:0] lo_addr_o,
  output logic [ADDR_W-1:0] hi_addr_o
);
  logic [3:0] nib;
  logic       is_hex;

  srec_hexconv u_hex (
    .ch_i     (char_i),
    .nib_o    (nib),
    .is_hex_o (is_hex)
  );

  srec_parser #(.ADDR_W(ADDR_W)) u_parse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ch_valid_i (char_valid_i),
    .ch_i       (char_i),
    .nib_i      (nib),
    .is_hex_i   (is_hex),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .rec_ok_o   (rec_ok_o),
    .eof_o      (eof_o),
    .err_o      (err_o),
    .err_code_o (err_code_o)
  );

  // range is cleared by the end-of-file pulse, so it is still intact while eof_o is high
  srec_range #(.ADDR_W(ADDR_W)) u_range (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr_valid_o),
    .addr_i (wr_addr_o),
    .clr_i  (eof_o),
    .lo_o   (lo_addr_o),
    .hi_o   (hi_addr_o)
  );
endmodule

// File: rtl/srec_decoder_chk.sv
module srec_decoder_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic              rec_ok_o,
  input logic              eof_o,
  input logic              err_o,
  input logic [2:0]        err_code_o,
  input logic [ADDR_W-1:0] lo_addr_o,
  input logic [ADDR_W-1:0] hi_addr_o
);
  logic              have_prev;
  logic [ADDR_W-1:0] prev_addr;
  logic              seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_prev <= 1'b0;
      prev_addr <= '0;
      seen      <= 1'b0;
    end else begin
      if (rec_ok_o || err_o) have_prev <= 1'b0;
      else if (wr_valid_o) begin
        have_prev <= 1'b1;
        prev_addr <= wr_addr_o;
      end
      if (eof_o) seen <= 1'b0;
      else if (wr_valid_o) seen <= 1'b1;
    end
  end

  assert_addr_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && have_prev) |-> (wr_addr_o == prev_addr + 1'b1));
  assert_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_valid_o, rec_ok_o, err_o}));
  assert_eof_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |-> rec_ok_o);
  assert_err_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o != 3'd0 && err_code_o <= 3'd4));
  assert_range_order_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eof_o && seen) |-> (lo_addr_o <= hi_addr_o));
  assert_range_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> (lo_addr_o == '1 && hi_addr_o == '0));
endmodule

bind srec_decoder srec_decoder_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .rec_ok_o   (rec_ok_o),
  .eof_o      (eof_o),
  .err_o      (err_o),
  .err_code_o (err_code_o),
  .lo_addr_o  (lo_addr_o),
  .hi_addr_o  (hi_addr_o)
);

// File: tb/srec_decoder_tb.sv
`timescale 1ns/1ps
module srec_decoder_tb;
  typedef struct packed {
    logic [3:0]  typ;
    logic [31:0] addr;
    logic [2:0]  n;
    logic [31:0] data;
    logic        bad;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{typ:4'h1, addr:32'h0000_0100, n:3'd4, data:32'h0102_0304, bad:1'b0},
    '{typ:4'h2, addr:32'h0012_3456, n:3'd2, data:32'hAABB_0000, bad:1'b0},
    '{typ:4'h3, addr:32'h0000_FFFE, n:3'd3, data:32'h1122_3300, bad:1'b0},
    '{typ:4'h1, addr:32'h0000_0200, n:3'd1, data:32'h5A00_0000, bad:1'b1},
    '{typ:4'h0, addr:32'h0000_0000, n:3'd3, data:32'h4844_5200, bad:1'b0},
    '{typ:4'h5, addr:32'h0000_0003, n:3'd0, data:32'h0,         bad:1'b0},
    '{typ:4'h9, addr:32'h0000_0100, n:3'd0, data:32'h0,         bad:1'b0},
    '{typ:4'h2, addr:32'h0000_0010, n:3'd1, data:32'hC300_0000, bad:1'b0},
    '{typ:4'h8, addr:32'h0000_0000, n:3'd0, data:32'h0,         bad:1'b0},
    '{typ:4'h3, addr:32'h8000_0000, n:3'd1, data:32'h7E00_0000, bad:1'b0},
    '{typ:4'h7, addr:32'h0000_0000, n:3'd0, data:32'h0,         bad:1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        char_valid = 1'b0;
  logic [7:0]  char_in = 8'h00;
  logic        wr_valid, rec_ok, eof, err;
  logic [31:0] wr_addr, lo_addr, hi_addr;
  logic [7:0]  wr_data;
  logic [2:0]  err_code;

  always #2.5 clk = ~clk;

  srec_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .char_valid_i(char_valid), .char_i(char_in),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rec_ok_o(rec_ok), .eof_o(eof), .err_o(err), .err_code_o(err_code),
    .lo_addr_o(lo_addr), .hi_addr_o(hi_addr)
  );

  int n_chk = 0, n_fail = 0;
  int wcnt, okcnt, errcnt, eofcnt;
  logic [31:0] waddr [16];
  logic [7:0]  wdat [16];
  logic [2:0]  last_code;
  logic [31:0] eof_lo, eof_hi;
  logic [31:0] exp_lo, exp_hi;

  always @(negedge clk) if (rst_n) begin
    if (wr_valid) begin
      if (wcnt < 16) begin waddr[wcnt] = wr_addr; wdat[wcnt] = wr_data; end
      wcnt++;
    end
    if (rec_ok) okcnt++;
    if (err) begin errcnt++; last_code = err_code; end
    if (eof) begin eofcnt++; eof_lo = lo_addr; eof_hi = hi_addr; end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    wcnt = 0; okcnt = 0; errcnt = 0; eofcnt = 0; last_code = 3'd0;
  endtask

  task automatic send_char(input logic [7:0] c, input bit gap);
    char_in = c; char_valid = 1'b1;
    @(negedge clk);
    char_valid = 1'b0;
    if (gap) begin char_in = "Z"; @(negedge clk); end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] v, input bit lower);
    if (v < 10) return 8'("0") + 8'(v);
    return (lower ? 8'("a") : 8'("A")) + 8'(v) - 8'd10;
  endfunction

  task automatic send_byte(input logic [7:0] b, input bit lower, input bit gap);
    send_char(hexch(b[7:4], lower), gap);
    send_char(hexch(b[3:0], lower), gap);
  endtask

  function automatic int alen(input logic [3:0] t);
    if (t == 4'd2 || t == 4'd8) return 3;
    if (t == 4'd3 || t == 4'd7) return 4;
    return 2;
  endfunction

  task automatic send_rec(input vec_t v, input bit lower, input bit gap);
    int al;
    logic [7:0] cnt, sum, b;
    al  = alen(v.typ);
    cnt = 8'(al + int'(v.n) + 1);
    sum = cnt;
    send_char("S", gap);
    send_char(8'("0") + 8'(v.typ), gap);
    send_byte(cnt, lower, gap);
    for (int i = al - 1; i >= 0; i--) begin
      b = v.addr[i*8 +: 8]; sum += b; send_byte(b, lower, gap);
    end
    for (int i = 0; i < int'(v.n); i++) begin
      b = v.data[31 - i*8 -: 8]; sum += b; send_byte(b, lower, gap);
    end
    b = 8'hFF - sum;
    if (v.bad) b = b ^ 8'h55;
    send_byte(b, lower, gap);
    repeat (3) @(negedge clk);
  endtask

  // checks one record's observed effects against the expectation derived from its fields
  task automatic check_rec(input vec_t v, input string tag);
    bit wr_t, eof_t;
    wr_t  = (v.typ == 4'd1 || v.typ == 4'd2 || v.typ == 4'd3);
    eof_t = (v.typ == 4'd7 || v.typ == 4'd8 || v.typ == 4'd9);
    chk(wcnt == (wr_t ? int'(v.n) : 0), {tag, " R2 R5 write count"}, wcnt, wr_t ? v.n : 0);
    if (wr_t) for (int i = 0; i < int'(v.n) && i < wcnt; i++) begin
      chk(waddr[i] == v.addr + i, {tag, " R2 R3 address"}, waddr[i], v.addr + i);
      chk(wdat[i] == v.data[31 - i*8 -: 8], {tag, " R2 data"}, wdat[i], v.data[31 - i*8 -: 8]);
      if (waddr[i] < exp_lo) exp_lo = waddr[i];
      if (waddr[i] > exp_hi) exp_hi = waddr[i];
    end
    chk(okcnt == (v.bad ? 0 : 1), {tag, " R4 record ok"}, okcnt, v.bad ? 0 : 1);
    chk(last_code == (v.bad ? 3'd4 : 3'd0), {tag, " R4 error code"}, last_code, v.bad ? 4 : 0);
    chk(eofcnt == ((eof_t && !v.bad) ? 1 : 0), {tag, " R6 eof"}, eofcnt, (eof_t && !v.bad) ? 1 : 0);
    if (eof_t && !v.bad) begin
      chk(eof_lo == exp_lo, {tag, " R10 low address"}, eof_lo, exp_lo);
      chk(eof_hi == exp_hi, {tag, " R10 high address"}, eof_hi, exp_hi);
      exp_lo = 32'hFFFF_FFFF; exp_hi = 32'h0;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    vec_t v;
    clr_mon();
    exp_lo = 32'hFFFF_FFFF; exp_hi = 32'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!wr_valid && !rec_ok && !eof && !err, "R1 pulses low", {wr_valid, rec_ok, eof, err}, 0);
    chk(lo_addr == 32'hFFFF_FFFF, "R1 low address", lo_addr, 32'hFFFF_FFFF);
    chk(hi_addr == 32'h0, "R1 high address", hi_addr, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      clr_mon();
      send_rec(VECS[k], 1'b0, 1'b0);
      check_rec(VECS[k], $sformatf("vec%0d", k));
    end
    chk(lo_addr == 32'hFFFF_FFFF && hi_addr == 32'h0, "R10 range cleared after eof", lo_addr, 32'hFFFF_FFFF);

    // R7: count 02 too small for S1; trailing digits must be ignored (R9)
    clr_mon();
    send_char("S", 0); send_char("1", 0); send_byte(8'h02, 0, 0); send_byte(8'hFD, 0, 0);
    repeat (3) @(negedge clk);
    chk(errcnt == 1 && last_code == 3'd3, "R7 short count error", last_code, 3);
    chk(wcnt == 0 && okcnt == 0, "R9 ignored after error", wcnt + okcnt, 0);

    // R8: type 4, then immediate resync on a good record (R9)
    clr_mon();
    send_char("S", 0); send_char("4", 0);
    repeat (2) @(negedge clk);
    chk(errcnt == 1 && last_code == 3'd2, "R8 type 4 error", last_code, 2);
    clr_mon();
    v = '{typ:4'h1, addr:32'h0000_3000, n:3'd2, data:32'h9988_0000, bad:1'b0};
    send_rec(v, 0, 0);
    check_rec(v, "R9 resync");

    // R8: non-digit type
    clr_mon();
    send_char("S", 0); send_char("X", 0);
    repeat (2) @(negedge clk);
    chk(errcnt == 1 && last_code == 3'd2, "R8 non-digit type error", last_code, 2);

    // R9: non-hex in count field, noise between records
    clr_mon();
    send_char("S", 0); send_char("1", 0); send_char("0", 0); send_char("G", 0);
    send_char(8'h0D, 0); send_char(8'h0A, 0); send_char("7", 0);
    repeat (2) @(negedge clk);
    chk(errcnt == 1 && last_code == 3'd1, "R9 non-hex error", last_code, 1);

    // R11: lower-case digits
    clr_mon();
    v = '{typ:4'h2, addr:32'h00AB_CDEF, n:3'd3, data:32'hFADE_BE00, bad:1'b0};
    send_rec(v, 1'b1, 1'b0);
    check_rec(v, "R11 lower case");

    // R12: idle cycles carrying junk characters
    clr_mon();
    v = '{typ:4'h1, addr:32'h0000_4000, n:3'd2, data:32'h1234_0000, bad:1'b0};
    send_rec(v, 1'b0, 1'b1);
    check_rec(v, "R12 gaps");

    // R10: eof closing the writes above; then eof with no writes
    clr_mon();
    v = '{typ:4'h9, addr:32'h0, n:3'd0, data:32'h0, bad:1'b0};
    send_rec(v, 0, 0);
    check_rec(v, "R10 eof after lower case and gaps");
    clr_mon();
    send_rec(v, 0, 0);
    check_rec(v, "R10 eof empty");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule